// File: doc/BRIEF.md
# Fractional-Increment System Time Counter

This block keeps a free-running 64-bit system time. Each time the reference oscillator strobe `osc_tick` is high for a clock cycle, the block adds a programmable increment to the time register. The increment is a binary fraction: software picks a right shift and takes the upper bits of the time as nanoseconds. Small changes to the increment trim the clock rate. The current time is also driven out on `time_now`, where neighbouring capture and compare logic can use it.

Software reaches the block through a request/response register port. Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while an earlier read response is still waiting, which means `rsp_valid` is high and `rsp_ready` is low. Writes give no response. Each accepted read gives one response, registered, in the cycle after acceptance. The response holds `rsp_valid` and `rsp_rdata` steady until a cycle where `rsp_ready` is high.

Register addresses are: 0 = increment, 1 = time low word, 2 = time high word, 3 = reserved (reads 0, writes ignored). The parameter `WIDE_MODE` selects the increment layout. `SPEED` selects the reset increment: 0 is the fast link, 1 is medium (10x tick period), 2 is slow (100x tick period). For those three settings, software uses nanosecond shifts of 28, 24 and 21.

Top module: `tsc_time_counter`

## Requirements
- R1: After reset the time register is 0. The increment register reads back 0x66666666 (SPEED 0), 0x40000000 (SPEED 1) or 0x50000000 (SPEED 2) in wide mode. In compact mode it reads back the same base shifted right by 7 in bits 23:0, with the period field (bits 31:24) set to 1. For SPEED 2 in compact mode this gives 0x01A00000.
- R2: Every cycle with `osc_tick` high adds the effective increment to the 64-bit time. The time register changes on the same clock edge.
- R3: When the increment value is zero, the time register does not change, however many ticks arrive.
- R4: A write to address 1 only stages a low word, and the time does not change. A write to address 2 loads {written high word, staged low word} into the time register at once. Writing 0 to address 1 and then 0 to address 2 resets the time to 0.
- R5: Reading address 1 returns time bits 31:0 and captures bits 63:32 in the same cycle. Reading address 2 returns that captured value. A low-then-high read pair is therefore coherent even when a carry crosses bit 32 between the two reads.
- R6: A write to address 0 does not change the time value. The new increment applies from the next tick after the write edge.
- R7: The time wraps modulo 2^64, with no saturation.
- R8: In wide mode the increment is bits 30:0 of the written word. Bit 31 is ignored and reads back 0.
- R9: In compact mode the increment is bits 23:0, and bits 31:24 hold a period P. The increment is added once every P ticks, and the tick count restarts at each increment write. P = 0 stops the time.
- R10: When a high-word write and a tick fall on the same edge, the load wins and that tick is dropped.
- R11: While a read response waits with `rsp_ready` low, `rsp_valid` and `rsp_rdata` hold and `req_ready` is low. A request presented in that state is ignored.
- R12: `time_now` always equals the time register that the register reads observe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator tick strobe, one add per high cycle |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_rdata | output | 32 | Read response data |
| time_now | output | 64 | Current system time |

## Verification
The bench builds two instances on shared stimulus. One is wide mode at the fast reset speed, and the other is compact mode at the slow reset speed. Together they cover both reset encodings, both increment layouts and the period gating. In the compact instance, the period field is swept from 0 to 4 over a fixed tick count, and each result is compared with the quotient of the count divided by P. The wide instance is loaded near the 32-bit carry and near the 64-bit wrap, so that the coherent split read and the modulo behaviour are exercised with only a few ticks.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [1:0] {
    TSC_A_INC = 2'd0,
    TSC_A_LO  = 2'd1,
    TSC_A_HI  = 2'd2,
    TSC_A_RSV = 2'd3
  } tsc_addr_e;

  localparam int unsigned TSC_COMPACT_DROP = 7;

  // Reset increment word for a speed class and layout.
  function automatic logic [31:0] tsc_reset_inc(input int unsigned speed, input bit wide);
    logic [31:0] base;
    case (speed)
      0:       base = 32'h6666_6666;
      1:       base = 32'h4000_0000;
      default: base = 32'h5000_0000;
    endcase
    if (wide) return base & 32'h7FFF_FFFF;
    return 32'h0100_0000 | (base >> TSC_COMPACT_DROP);
  endfunction

endpackage

// File: rtl/tsc_regif.sv
module tsc_regif
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic [TIME_W-1:0] time_q,
  input  logic [WORD_W-1:0] inc_rd,
  output logic              inc_we,
  output logic [WORD_W-1:0] inc_wdata,
  output logic              load_en,
  output logic [TIME_W-1:0] load_val
);

  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic [WORD_W-1:0] lo_stage_q;
  logic [WORD_W-1:0] hi_snap_q;
  logic              fire, wr_fire, rd_fire;
  logic [WORD_W-1:0] rd_mux;
  tsc_addr_e         addr;

  assign addr      = tsc_addr_e'(req_addr);
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;

  assign inc_we    = wr_fire && (addr == TSC_A_INC);
  assign inc_wdata = req_wdata;
  assign load_en   = wr_fire && (addr == TSC_A_HI);
  assign load_val  = {req_wdata, lo_stage_q};

  always_comb begin
    case (addr)
      TSC_A_INC: rd_mux = inc_rd;
      TSC_A_LO:  rd_mux = time_q[WORD_W-1:0];
      TSC_A_HI:  rd_mux = hi_snap_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_stage_q <= '0;
      hi_snap_q  <= '0;
    end else begin
      if (wr_fire && (addr == TSC_A_LO)) lo_stage_q <= req_wdata;
      if (rd_fire && (addr == TSC_A_LO)) hi_snap_q  <= time_q[TIME_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_fire) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

endmodule

// File: rtl/tsc_incr.sv
module tsc_incr
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter bit          WIDE_MODE = 1'b1,
  parameter int unsigned SPEED     = 0,
  parameter int unsigned PER_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              inc_we,
  input  logic [WORD_W-1:0] inc_wdata,
  output logic              add_en,
  output logic [WORD_W-1:0] add_val,
  output logic [WORD_W-1:0] inc_rd
);

  localparam logic [31:0]  RST_WORD = tsc_reset_inc(SPEED, WIDE_MODE);
  localparam int unsigned  IW_WIDE  = WORD_W - 1;
  localparam int unsigned  IW_CMP   = WORD_W - PER_W;

  generate
    if (WIDE_MODE) begin : g_wide
      logic [IW_WIDE-1:0] inc_q;

      always_ff @(posedge clk) begin
        if (!rst_n)      inc_q <= RST_WORD[IW_WIDE-1:0];
        else if (inc_we) inc_q <= inc_wdata[IW_WIDE-1:0];
      end

      assign inc_rd  = {1'b0, inc_q};
      assign add_val = {1'b0, inc_q};
      assign add_en  = tick && (inc_q != '0);
    end else begin : g_compact
      logic [IW_CMP-1:0] inc_q;
      logic [PER_W-1:0]  per_q;
      logic [PER_W-1:0]  cnt_q;
      logic [PER_W:0]    cnt_nx;
      logic              due;

      assign cnt_nx = {1'b0, cnt_q} + {{PER_W{1'b0}}, 1'b1};
      assign due    = (per_q != '0) && (cnt_nx >= {1'b0, per_q});

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          inc_q <= RST_WORD[IW_CMP-1:0];
          per_q <= RST_WORD[WORD_W-1 -: PER_W];
          cnt_q <= '0;
        end else if (inc_we) begin
          inc_q <= inc_wdata[IW_CMP-1:0];
          per_q <= inc_wdata[WORD_W-1 -: PER_W];
          cnt_q <= '0;
        end else if (tick && (per_q != '0)) begin
          cnt_q <= due ? '0 : cnt_nx[PER_W-1:0];
        end
      end

      assign inc_rd  = {per_q, inc_q};
      assign add_val = {{PER_W{1'b0}}, inc_q};
      assign add_en  = tick && due && (inc_q != '0);
    end
  endgenerate

endmodule

// File: rtl/tsc_accum.sv
module tsc_accum #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic [WORD_W-1:0] add_val,
  input  logic              load_en,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)       time_q <= '0;
    else if (load_en) time_q <= load_val;
    else if (add_en)  time_q <= time_q + {{WORD_W{1'b0}}, add_val};
  end

endmodule

// File: rtl/tsc_time_counter.sv
module tsc_time_counter
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter bit          WIDE_MODE = 1'b1,
  parameter int unsigned SPEED     = 0,
  parameter int unsigned PER_W     = 8,
  localparam int unsigned TIME_W   = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [TIME_W-1:0] time_now
);

  logic              inc_we;
  logic [WORD_W-1:0] inc_wdata;
  logic [WORD_W-1:0] inc_rd;
  logic              add_en;
  logic [WORD_W-1:0] add_val;
  logic              load_en;
  logic [TIME_W-1:0] load_val;
  logic [TIME_W-1:0] time_q;

  tsc_regif #(.WORD_W(WORD_W)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .time_q(time_q), .inc_rd(inc_rd),
    .inc_we(inc_we), .inc_wdata(inc_wdata),
    .load_en(load_en), .load_val(load_val)
  );

  tsc_incr #(.WORD_W(WORD_W), .WIDE_MODE(WIDE_MODE), .SPEED(SPEED), .PER_W(PER_W)) u_incr (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick),
    .inc_we(inc_we), .inc_wdata(inc_wdata),
    .add_en(add_en), .add_val(add_val), .inc_rd(inc_rd)
  );

  tsc_accum #(.WORD_W(WORD_W)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .add_en(add_en), .add_val(add_val),
    .load_en(load_en), .load_val(load_val),
    .time_q(time_q)
  );

  assign time_now = time_q;

endmodule

// File: rtl/tsc_time_counter_chk.sv
module tsc_time_counter_chk #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic [TIME_W-1:0] time_now,
  input logic              add_en,
  input logic [WORD_W-1:0] add_val,
  input logic              load_en,
  input logic [TIME_W-1:0] load_val
);

  // R2, R7: an add step advances time by the increment, modulo 2^64
  a_r2_add_step: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !load_en) |=> (time_now == $past(time_now) + {{WORD_W{1'b0}}, $past(add_val)}));

  // R3: a zero increment never produces an add step
  a_r3_zero_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |-> (add_val != '0));

  // R4, R10: a high-word write loads the full value, even with a tick
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (time_now == $past(load_val)));

  // R6: without a load or add step the time holds
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !load_en) |=> $stable(time_now));

  // R11: a stalled response holds its data
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R11: no new request while a response waits
  a_r11_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind tsc_time_counter tsc_time_counter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .time_now(time_now), .add_en(add_en), .add_val(add_val),
  .load_en(load_en), .load_val(load_val)
);

// File: tb/tb_tsc_time_counter.sv
module tb_tsc_time_counter;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, osc_tick, req_write;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic        vw, vc, rsp_ready_w;
  logic        rdy_w, rdy_c, rv_w, rv_c;
  logic [31:0] rd_w, rd_c;
  logic [63:0] tn_w, tn_c;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tsc_time_counter #(.WIDE_MODE(1'b1), .SPEED(0)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .req_valid(vw), .req_ready(rdy_w), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv_w), .rsp_ready(rsp_ready_w), .rsp_rdata(rd_w),
    .time_now(tn_w)
  );

  tsc_time_counter #(.WIDE_MODE(1'b0), .SPEED(2)) dut_c (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .req_valid(vc), .req_ready(rdy_c), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv_c), .rsp_ready(1'b1), .rsp_rdata(rd_c),
    .time_now(tn_c)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [1:0] a, input logic [31:0] d, input bit tk = 1'b0);
    @(negedge clk);
    req_write = 1'b1; req_addr = a; req_wdata = d; osc_tick = tk;
    if (sel) vc = 1'b1; else vw = 1'b1;
    @(negedge clk);
    vw = 1'b0; vc = 1'b0; osc_tick = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_write = 1'b0; req_addr = a;
    if (sel) vc = 1'b1; else vw = 1'b1;
    @(negedge clk);
    vw = 1'b0; vc = 1'b0;
    d = sel ? rd_c : rd_w;
  endtask

  task automatic rd64(input bit sel, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(sel, 2'd1, lo);
    rd(sel, 2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic load(input bit sel, input logic [63:0] v);
    wr(sel, 2'd1, v[31:0]);
    wr(sel, 2'd2, v[63:32]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [63:0] t, t0;
    rst_n = 1'b0; osc_tick = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    vw = 1'b0; vc = 1'b0; rsp_ready_w = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, 2'd0, w); chk("R1 wide inc", 64'(w), 64'h6666_6666);
    rd(1, 2'd0, w); chk("R1 compact inc", 64'(w), 64'h01A0_0000);
    rd64(0, t); chk("R1 wide time", t, 64'h0);
    rd64(1, t); chk("R1 compact time", t, 64'h0);

    // R2 and R12
    load(0, 64'h0); ticks(5);
    rd64(0, t); chk("R2 five ticks", t, 64'd5 * 64'h6666_6666);
    chk("R12 export", tn_w, 64'd5 * 64'h6666_6666);
    wr(0, 2'd0, 32'h0001_2345); load(0, 64'h1000_0000); ticks(7);
    rd64(0, t); chk("R2 custom inc", t, 64'h1000_0000 + 64'd7 * 64'h1_2345);

    // R6 increment write leaves time, then applies
    rd64(0, t0);
    wr(0, 2'd0, 32'h100);
    rd64(0, t); chk("R6 time undisturbed", t, t0);
    ticks(3);
    rd64(0, t); chk("R6 new inc applies", t, t0 + 64'h300);

    // R3 zero increment
    wr(0, 2'd0, 32'h0); ticks(10);
    rd64(0, t); chk("R3 zero inc hold", t, t0 + 64'h300);
    chk("R12 export hold", tn_w, t0 + 64'h300);

    // R7 wrap
    wr(0, 2'd0, 32'h20); load(0, 64'hFFFF_FFFF_FFFF_FFF0); ticks(1);
    rd64(0, t); chk("R7 wrap", t, 64'h10);

    // R5 coherent split read across a carry
    load(0, 64'h1_FFFF_FFF0);
    rd(0, 2'd1, w); chk("R5 low word", 64'(w), 64'hFFFF_FFF0);
    ticks(1);
    rd(0, 2'd2, w); chk("R5 snapshot high", 64'(w), 64'h1);
    rd64(0, t); chk("R5 after carry", t, 64'h2_0000_0010);

    // R4 staged load and reset by zeros
    load(0, 64'hDEAD_BEEF_0123_4567);
    rd64(0, t); chk("R4 load", t, 64'hDEAD_BEEF_0123_4567);
    wr(0, 2'd1, 32'h0);
    rd64(0, t); chk("R4 low write alone", t, 64'hDEAD_BEEF_0123_4567);
    wr(0, 2'd2, 32'h0);
    rd64(0, t); chk("R4 zero reset", t, 64'h0);

    // R10 load beats coincident tick
    wr(0, 2'd1, 32'h5);
    wr(0, 2'd2, 32'h7, 1'b1);
    rd64(0, t); chk("R10 load wins", t, 64'h7_0000_0005);

    // R8 wide layout ignores bit 31
    wr(0, 2'd0, 32'hFFFF_FFFF);
    rd(0, 2'd0, w); chk("R8 readback", 64'(w), 64'h7FFF_FFFF);
    load(0, 64'h0); ticks(2);
    rd64(0, t); chk("R8 add", t, 64'd2 * 64'h7FFF_FFFF);

    // R9 compact mode, default period 1 then sweep
    load(1, 64'h0); ticks(4);
    rd64(1, t); chk("R9 reset period", t, 64'd4 * 64'hA0_0000);
    for (int p = 0; p <= 4; p++) begin
      wr(1, 2'd0, (32'(p) << 24) | 32'h100);
      rd(1, 2'd0, w); chk("R9 readback", 64'(w), 64'((32'(p) << 24) | 32'h100));
      load(1, 64'h0); ticks(12);
      rd64(1, t);
      chk("R9 period sweep", t, (p == 0) ? 64'h0 : 64'(12 / p) * 64'h100);
    end

    // R11 back-pressure
    wr(0, 2'd0, 32'h11);
    rsp_ready_w = 1'b0;
    @(negedge clk); req_write = 1'b0; req_addr = 2'd0; vw = 1'b1;
    @(negedge clk); vw = 1'b0;
    chk("R11 valid", 64'(rv_w), 64'h1);
    chk("R11 ready low", 64'(rdy_w), 64'h0);
    @(negedge clk); req_write = 1'b1; req_addr = 2'd0; req_wdata = 32'h55; vw = 1'b1;
    @(negedge clk); vw = 1'b0; req_write = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 hold valid", 64'(rv_w), 64'h1);
    chk("R11 hold data", 64'(rd_w), 64'h11);
    rsp_ready_w = 1'b1;
    @(negedge clk);
    chk("R11 drained", 64'(rv_w), 64'h0);
    rd(0, 2'd0, w); chk("R11 stalled write ignored", 64'(w), 64'h11);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule